// File: doc/BRIEF.md
# Comparator Power-State Control Wrapper

This block is the digital shell around an analog voltage comparator. It brings the asynchronous compare result into the clock domain, detects its rising and falling transitions into sticky flags, raises an interrupt and a wakeup request from those flags, drives the result to a device pin, and tells the analog core which speed setting to use. It also holds a small control register with the pin enable, the speed bit, the enables of the window, sample and filter paths, and two interrupt enables.

The chip power state, given as a two-bit code, changes how the block behaves. Run and debug are identical. Stop keeps the full function. Low-leakage forces the low-speed setting, turns off the three processing paths, and freezes the pin at the value it had just before entry. When the chip leaves low-leakage, the control register and the pin latch return to their reset values, but the two edge flags keep their state. This tells software which edge caused the wakeup. An external reset clears everything, flags included. The processing paths themselves are not modelled here. Only their effective enables come out of the block.

Top module: `cmp_pwr_wrap`

## Requirements
- R1: The compare input passes through SYNC_STAGES flops to `cmp_sync`. A 0-to-1 change of `cmp_sync` sets `rise_flag`, and a 1-to-0 change sets `fall_flag`, one clock later. With the default two stages, a flag is set by the third rising clock edge after the input changes.
- R2: Writing `flag_clr_we` with `flag_clr[0]`=1 clears `rise_flag`, and `flag_clr[1]`=1 clears `fall_flag`. If a clear and a new edge meet on the same clock, the flag stays set.
- R3: `irq_req` equals (`rise_flag` AND ie_rise) OR (`fall_flag` AND ie_fall). `wake_req` equals `irq_req` in stop (code 1) and low-leakage (code 2), and is 0 in run (code 0) and debug (code 3).
- R4: In run, stop and debug, `pin_out` equals `cmp_sync` AND the pin-enable bit.
- R5: `hs_sel` equals the speed bit in run, stop and debug. It is 0 in low-leakage, whatever the speed bit holds.
- R6: `win_path_en`, `smp_path_en` and `flt_path_en` follow their control bits outside low-leakage and are 0 in low-leakage.
- R7: In low-leakage, `pin_out` holds the value it had on the last cycle before entry and ignores the compare input.
- R8: On the first clock in which the power state leaves low-leakage, the control register returns to CTRL_RST and the pin latch to 0. `rise_flag` and `fall_flag` keep their values.
- R9: While `rst_n` is low, the control register, both flags and the pin latch are at their reset values. The control register reset value is CTRL_RST.
- R10: Debug (code 3) produces the same outputs as run for the same control value and input.
- R11: A write with `ctrl_we` loads `ctrl_wdata` into the control register, which is read back on `ctrl_rd`. The bit layout is: bit0 pin enable, bit1 speed (1 = high speed), bit2 window enable, bit3 sample enable, bit4 filter enable, bit5 ie_rise, bit6 ie_fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, clears all state |
| pwr_state | input | 2 | 0 run, 1 stop, 2 low-leakage, 3 debug |
| cmp_raw | input | 1 | Asynchronous analog compare result |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 7 | Control register write data |
| flag_clr_we | input | 1 | Flag clear strobe |
| flag_clr | input | 2 | Write-1-to-clear mask: bit0 rise, bit1 fall |
| ctrl_rd | output | 7 | Control register contents |
| rise_flag | output | 1 | Sticky rising-edge flag |
| fall_flag | output | 1 | Sticky falling-edge flag |
| irq_req | output | 1 | Interrupt request |
| wake_req | output | 1 | Wakeup request in stop or low-leakage |
| pin_out | output | 1 | Value driven to the device pin |
| hs_sel | output | 1 | Effective speed select, 1 = high speed |
| win_path_en | output | 1 | Effective window path enable |
| smp_path_en | output | 1 | Effective sample path enable |
| flt_path_en | output | 1 | Effective filter path enable |
| cmp_sync | output | 1 | Synchronized compare result |

## Verification
The bench builds the block with its defaults: two synchronizer stages and an all-zero reset value. With these settings every edge lands on a known clock, the third after the input changes. Because the control word is only seven bits wide, the sweep covers every control value in every power state with both starting input levels. This reaches each effective-enable combination, each interrupt-enable pairing with each edge direction, and each entry into and exit from low-leakage. Extra directed cases cover a clear that coincides with a new edge, and an external reset while flags are set.

// File: rtl/cmpw_pkg.sv
package cmpw_pkg;
   typedef enum logic [1:0] {
      PWR_RUN  = 2'd0,
      PWR_STOP = 2'd1,
      PWR_LLK  = 2'd2,
      PWR_DBG  = 2'd3
   } pwr_e;

   localparam int CTRL_W = 7;

   // bit0 is oe, bit6 is ie_fall
   typedef struct packed {
      logic ie_fall;
      logic ie_rise;
      logic flt_en;
      logic smp_en;
      logic win_en;
      logic hs;
      logic oe;
   } ctrl_t;
endpackage

// File: rtl/cmpw_sync.sv
module cmpw_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("cmpw_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= RST_VAL;
               else        chain_q[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gi] <= RST_VAL;
               else        chain_q[gi] <= chain_q[gi-1];
            end
         end
      end
   endgenerate

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cmpw_ctrl_regs.sv
module cmpw_ctrl_regs
   import cmpw_pkg::*;
#(
   parameter logic [CTRL_W-1:0] RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wake_clear,
   input  logic              we,
   input  logic [CTRL_W-1:0] wdata,
   output ctrl_t             q
);
   ctrl_t q_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q_r <= ctrl_t'(RST);
      else if (wake_clear) q_r <= ctrl_t'(RST);
      else if (we)         q_r <= ctrl_t'(wdata);
   end

   assign q = q_r;
endmodule

// File: rtl/cmpw_edge_flags.sv
module cmpw_edge_flags (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       d_sync,
   input  logic       clr_we,
   input  logic [1:0] clr,
   output logic       rise,
   output logic       fall
);
   logic prev_q;
   logic rise_q, fall_q;
   logic rise_ev, fall_ev;

   assign rise_ev = d_sync & ~prev_q;
   assign fall_ev = ~d_sync & prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         rise_q <= 1'b0;
         fall_q <= 1'b0;
      end else begin
         prev_q <= d_sync;
         // a new edge wins over a clear on the same cycle
         rise_q <= rise_ev | (rise_q & ~(clr_we & clr[0]));
         fall_q <= fall_ev | (fall_q & ~(clr_we & clr[1]));
      end
   end

   assign rise = rise_q;
   assign fall = fall_q;
endmodule

// File: rtl/cmpw_pin_hold.sv
module cmpw_pin_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic wake_clear,
   input  logic hold,
   input  logic live,
   output logic pin
);
   logic last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          last_q <= 1'b0;
      else if (wake_clear) last_q <= 1'b0;
      else if (!hold)      last_q <= live;
   end

   assign pin = hold ? last_q : live;
endmodule

// File: rtl/cmp_pwr_wrap.sv
module cmp_pwr_wrap
   import cmpw_pkg::*;
#(
   parameter int                SYNC_STAGES = 2,
   parameter logic [CTRL_W-1:0] CTRL_RST    = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        pwr_state,
   input  logic              cmp_raw,
   input  logic              ctrl_we,
   input  logic [CTRL_W-1:0] ctrl_wdata,
   input  logic              flag_clr_we,
   input  logic [1:0]        flag_clr,
   output logic [CTRL_W-1:0] ctrl_rd,
   output logic              rise_flag,
   output logic              fall_flag,
   output logic              irq_req,
   output logic              wake_req,
   output logic              pin_out,
   output logic              hs_sel,
   output logic              win_path_en,
   output logic              smp_path_en,
   output logic              flt_path_en,
   output logic              cmp_sync
);
   pwr_e  pwr;
   pwr_e  pwr_q;
   logic  in_llk, llk_exit, low_power;
   ctrl_t ctrl;
   logic  s_q;

   assign pwr       = pwr_e'(pwr_state);
   assign in_llk    = (pwr == PWR_LLK);
   assign low_power = (pwr == PWR_STOP) || in_llk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pwr_q <= PWR_RUN;
      else        pwr_q <= pwr;
   end

   assign llk_exit = (pwr_q == PWR_LLK) && !in_llk;

   cmpw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (cmp_raw),
      .q     (s_q)
   );

   cmpw_ctrl_regs #(.RST(CTRL_RST)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wake_clear (llk_exit),
      .we         (ctrl_we),
      .wdata      (ctrl_wdata),
      .q          (ctrl)
   );

   cmpw_edge_flags u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_sync (s_q),
      .clr_we (flag_clr_we),
      .clr    (flag_clr),
      .rise   (rise_flag),
      .fall   (fall_flag)
   );

   cmpw_pin_hold u_pin (
      .clk        (clk),
      .rst_n      (rst_n),
      .wake_clear (llk_exit),
      .hold       (in_llk),
      .live       (ctrl.oe & s_q),
      .pin        (pin_out)
   );

   assign hs_sel      = ctrl.hs     & ~in_llk;
   assign win_path_en = ctrl.win_en & ~in_llk;
   assign smp_path_en = ctrl.smp_en & ~in_llk;
   assign flt_path_en = ctrl.flt_en & ~in_llk;

   assign irq_req  = (rise_flag & ctrl.ie_rise) | (fall_flag & ctrl.ie_fall);
   assign wake_req = irq_req & low_power;
   assign ctrl_rd  = ctrl;
   assign cmp_sync = s_q;
endmodule

// File: rtl/cmp_pwr_wrap_chk.sv
module cmp_pwr_wrap_chk
   import cmpw_pkg::*;
#(
   parameter logic [CTRL_W-1:0] CTRL_RST = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        pwr_state,
   input logic [CTRL_W-1:0] ctrl_rd,
   input logic              irq_req,
   input logic              wake_req,
   input logic              pin_out,
   input logic              hs_sel,
   input logic              win_path_en,
   input logic              smp_path_en,
   input logic              flt_path_en
);
   logic seen_clk;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_clk <= 1'b0;
      else        seen_clk <= 1'b1;
   end

   // R5
   llk_low_speed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 2'd2) |-> !hs_sel);

   // R6
   llk_paths_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 2'd2) |-> !(win_path_en | smp_path_en | flt_path_en));

   // R7
   llk_pin_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_clk && pwr_state == 2'd2 && $past(pwr_state) == 2'd2) |-> $stable(pin_out));

   // R3
   wake_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> (irq_req && (pwr_state == 2'd1 || pwr_state == 2'd2)));

   // R8
   llk_exit_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_clk && $past(pwr_state) == 2'd2 && pwr_state != 2'd2) |=> (ctrl_rd == CTRL_RST));
endmodule

bind cmp_pwr_wrap cmp_pwr_wrap_chk #(.CTRL_RST(CTRL_RST)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pwr_state   (pwr_state),
   .ctrl_rd     (ctrl_rd),
   .irq_req     (irq_req),
   .wake_req    (wake_req),
   .pin_out     (pin_out),
   .hs_sel      (hs_sel),
   .win_path_en (win_path_en),
   .smp_path_en (smp_path_en),
   .flt_path_en (flt_path_en)
);

// File: tb/cmp_pwr_wrap_tb_top.sv
module cmp_pwr_wrap_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] pwr_state = 2'd0;
   logic       cmp_raw = 1'b0;
   logic       ctrl_we = 1'b0;
   logic [6:0] ctrl_wdata = '0;
   logic       flag_clr_we = 1'b0;
   logic [1:0] flag_clr = '0;
   logic [6:0] ctrl_rd;
   logic rise_flag, fall_flag, irq_req, wake_req, pin_out, hs_sel;
   logic win_path_en, smp_path_en, flt_path_en, cmp_sync;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   cmp_pwr_wrap dut_i (
      .clk(clk), .rst_n(rst_n), .pwr_state(pwr_state), .cmp_raw(cmp_raw),
      .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .flag_clr_we(flag_clr_we),
      .flag_clr(flag_clr), .ctrl_rd(ctrl_rd), .rise_flag(rise_flag),
      .fall_flag(fall_flag), .irq_req(irq_req), .wake_req(wake_req),
      .pin_out(pin_out), .hs_sel(hs_sel), .win_path_en(win_path_en),
      .smp_path_en(smp_path_en), .flt_path_en(flt_path_en), .cmp_sync(cmp_sync)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr_ctrl(input logic [6:0] v);
      ctrl_we = 1'b1; ctrl_wdata = v;
      step(1);
      ctrl_we = 1'b0;
   endtask

   task automatic clr_flags(input logic [1:0] m);
      flag_clr_we = 1'b1; flag_clr = m;
      step(1);
      flag_clr_we = 1'b0; flag_clr = '0;
   endtask

   initial begin
      step(3);
      chk("R9 reset ctrl", ctrl_rd, 7'h00);
      chk("R9 reset flags", {5'b0, rise_flag, fall_flag}, 7'h00);
      chk("R9 reset pin", {6'b0, pin_out}, 7'h00);
      rst_n = 1'b1;
      step(2);

      for (int p = 0; p < 4; p++) begin
         for (int v = 0; v < 128; v++) begin
            for (int c = 0; c < 2; c++) begin
               logic [6:0] cv;
               logic exp_r, exp_f, exp_irq, llk;
               cv = 7'(v);
               llk = (p == 2);
               pwr_state = 2'd0;
               wr_ctrl(cv);
               chk("R11 readback", ctrl_rd, cv);
               cmp_raw = c[0];
               step(4);
               clr_flags(2'b11);
               chk("R2 cleared", {5'b0, rise_flag, fall_flag}, 7'h00);
               pwr_state = 2'(p);
               step(1);
               // R4 R10 pin before toggle, R5 R6 effective selects
               chk("R4/R7 pin", {6'b0, pin_out}, {6'b0, cv[0] & c[0]});
               chk("R5 hs_sel", {6'b0, hs_sel}, {6'b0, cv[1] & !llk});
               chk("R6 paths", {4'b0, flt_path_en, smp_path_en, win_path_en},
                   {4'b0, cv[4:2] & {3{!llk}}});
               cmp_raw = ~c[0];
               step(4);
               exp_r = (c == 0);
               exp_f = (c == 1);
               chk("R1 edge flags", {5'b0, rise_flag, fall_flag}, {5'b0, exp_r, exp_f});
               chk("R1 cmp_sync", {6'b0, cmp_sync}, {6'b0, ~c[0]});
               if (llk) chk("R7 pin held", {6'b0, pin_out}, {6'b0, cv[0] & c[0]});
               else     chk("R4 R10 pin live", {6'b0, pin_out}, {6'b0, cv[0] & ~c[0]});
               exp_irq = (exp_r & cv[5]) | (exp_f & cv[6]);
               chk("R3 irq", {6'b0, irq_req}, {6'b0, exp_irq});
               chk("R3 wake", {6'b0, wake_req}, {6'b0, exp_irq & (p == 1 || p == 2)});
               pwr_state = 2'd0;
               step(2);
               if (llk) begin
                  chk("R8 ctrl reset", ctrl_rd, 7'h00);
                  chk("R8 flags kept", {5'b0, rise_flag, fall_flag}, {5'b0, exp_r, exp_f});
                  chk("R8 pin reset", {6'b0, pin_out}, 7'h00);
               end else begin
                  chk("R11 ctrl kept", ctrl_rd, cv);
               end
            end
         end
      end

      // R2: clear coinciding with a new rise edge keeps the flag
      pwr_state = 2'd0;
      cmp_raw = 1'b0;
      step(4);
      clr_flags(2'b11);
      cmp_raw = 1'b1;
      step(2);
      flag_clr_we = 1'b1; flag_clr = 2'b01;
      step(1);
      flag_clr_we = 1'b0; flag_clr = '0;
      chk("R2 set wins", {6'b0, rise_flag}, 7'h01);
      clr_flags(2'b01);
      chk("R2 rise cleared", {6'b0, rise_flag}, 7'h00);

      // R9: external reset clears flags and control
      wr_ctrl(7'h7f);
      cmp_raw = 1'b0;
      step(4);
      chk("R9 fall set pre-reset", {6'b0, fall_flag}, 7'h01);
      rst_n = 1'b0;
      step(1);
      chk("R9 ctrl", ctrl_rd, 7'h00);
      chk("R9 flags", {5'b0, rise_flag, fall_flag}, 7'h00);
      rst_n = 1'b1;
      step(2);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule